// File: doc/BRIEF.md
# Dual-Buffer Frame Fetch Sequencer

This block generates the memory read requests that a display controller uses to pull a colour lookup table and pixel data out of memory. Each request carries a byte address and a word count, and it stays asserted until the memory side acknowledges it. A completed acknowledge means the whole burst has been transferred. A fetch pass walks one region from its start address up to its inclusive ceiling address, one burst at a time. The final burst of a region is shortened so that it never reads past the ceiling.

Two ping-pong frame buffers are described by start/ceiling pairs. When alternation is enabled, the sequencer swaps between the two buffers after each pass. When it is disabled, the sequencer re-reads buffer 0. A two-bit load selector chooses one of three sequences: the lookup table followed by the frames, the lookup table alone, or the frames alone. The lookup table is 32 bytes long, or 512 bytes when an 8-bit-per-pixel format is in use. One-cycle flags mark the end of each buffer and the completion of the table load.

Top module: `frame_fetch_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_req`, `frm0_done`, `frm1_done` and `lut_done` are all low.
- R2: `burst_sel` is sampled when a fetch starts. Codes 0, 1, 2, 3 and 4 give bursts of 1, 2, 4, 8 and 16 words (`rd_words`) whenever at least that many words remain in the region.
- R3: Within a region, the first request uses the region's start address, and each later request begins exactly `4 * rd_words` bytes after the previous one.
- R4: A burst that would cross the inclusive ceiling is shortened to the number of 4-byte words left. No request ever covers a byte above the ceiling.
- R5: `frm0_done` or `frm1_done` pulses high for one cycle, in the cycle after the acknowledge of the last burst of buffer 0 or buffer 1. At most one of the three flags is high at a time.
- R6: With `alt_buf_en` high, successive frame passes alternate buffer 0, buffer 1, buffer 0. With it low, every pass re-reads buffer 0.
- R7: With `load_sel` = 0, the table region at `lut_base` is fetched first, and `lut_done` pulses after its last burst. Frames then follow, starting with buffer 0. The table spans 32 bytes, or 512 bytes when `lut_wide` is high.
- R8: With `load_sel` = 1, only the table is fetched, and `lut_done` pulses once. No further request is made while `fetch_en` stays high. A new pass begins only after `fetch_en` goes low and then high again.
- R9: With `load_sel` = 2, the first request goes to buffer 0's start address.
- R10: Buffer start and ceiling inputs are captured when that buffer's pass begins. Rewriting them during a pass has no effect until the next pass of that buffer.
- R11: When `fetch_en` drops, an outstanding request is held until it is acknowledged. After that acknowledge, no new request is made.
- R12: Once raised, `rd_req` stays high with `rd_addr` and `rd_words` unchanged until `rd_ack` is seen high at a clock edge.
- R13: `burst_sel` codes 5 to 7 and `load_sel` code 3 are invalid, and with them no fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_en | input | 1 | Run request for the sequencer |
| load_sel | input | 2 | 0 table then frames, 1 table only, 2 frames only, 3 invalid |
| burst_sel | input | 3 | Burst length code (words = 2^code, codes 0..4) |
| alt_buf_en | input | 1 | Alternate between buffer 0 and buffer 1 |
| lut_base | input | AW | Byte start address of the lookup table |
| lut_wide | input | 1 | Table is 512 bytes instead of 32 |
| buf0_start | input | AW | Buffer 0 start byte address |
| buf0_ceil | input | AW | Buffer 0 inclusive ceiling byte address |
| buf1_start | input | AW | Buffer 1 start byte address |
| buf1_ceil | input | AW | Buffer 1 inclusive ceiling byte address |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | AW | Byte address of the burst |
| rd_words | output | 5 | Words in the burst (1..16) |
| rd_ack | input | 1 | Burst accepted and complete |
| frm0_done | output | 1 | Pulse: buffer 0 pass finished |
| frm1_done | output | 1 | Pulse: buffer 1 pass finished |
| lut_done | output | 1 | Pulse: table fetch finished |

## Verification
The tests use regions whose word counts are exact multiples of the burst length, and regions that are not. The first kind checks the plain address stepping. The second checks that the last burst is clipped to the ceiling. Every legal burst code is used, so a wrong length mapping shows up as a wrong `rd_words`. Alternation on and off are compared on the same descriptors, so an order of end-of-frame flags that is wrong on one side is exposed. Descriptors are also rewritten partway through a pass, and the fetch is dropped while a request is still pending, to tell apart capture at pass start from live use of the inputs.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_HOLD} seq_state_t;

  localparam logic [1:0] LS_LUT_FRM = 2'd0;
  localparam logic [1:0] LS_LUT_ONLY = 2'd1;
  localparam logic [1:0] LS_FRM_ONLY = 2'd2;
  localparam int LEN_W = 5;

  function automatic logic burst_code_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic [LEN_W-1:0] burst_code_words(input logic [2:0] code);
    case (code)
      3'd0: return 5'd1;
      3'd1: return 5'd2;
      3'd2: return 5'd4;
      3'd3: return 5'd8;
      3'd4: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/fetch_seg_sel.sv
module fetch_seg_sel #(
  parameter int AW = 32,
  parameter int LUT_SMALL_BYTES = 32,
  parameter int LUT_LARGE_BYTES = 512
) (
  input  logic          to_lut,
  input  logic          buf_sel,
  input  logic [AW-1:0] lut_base,
  input  logic          lut_wide,
  input  logic [AW-1:0] buf0_start,
  input  logic [AW-1:0] buf0_ceil,
  input  logic [AW-1:0] buf1_start,
  input  logic [AW-1:0] buf1_ceil,
  output logic [AW-1:0] seg_start,
  output logic [AW-1:0] seg_ceil
);
  localparam logic [AW-1:0] SMALL_SPAN = AW'(LUT_SMALL_BYTES - 1);
  localparam logic [AW-1:0] LARGE_SPAN = AW'(LUT_LARGE_BYTES - 1);

  always_comb begin
    if (to_lut) begin
      seg_start = lut_base;
      seg_ceil  = lut_base + (lut_wide ? LARGE_SPAN : SMALL_SPAN);
    end else if (buf_sel) begin
      seg_start = buf1_start;
      seg_ceil  = buf1_ceil;
    end else begin
      seg_start = buf0_start;
      seg_ceil  = buf0_ceil;
    end
  end
endmodule

// File: rtl/fetch_burst_calc.sv
module fetch_burst_calc #(
  parameter int AW = 32,
  parameter int WB_LG2 = 2
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] cur_ceil,
  input  logic [4:0]    max_words,
  output logic [4:0]    burst_words,
  output logic          final_burst,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] words_left;
  logic [AW-1:0] max_ext;

  always_comb begin
    words_left  = ((cur_ceil - cur_addr) >> WB_LG2) + AW'(1);
    max_ext     = {{(AW-5){1'b0}}, max_words};
    final_burst = (words_left <= max_ext);
    burst_words = final_burst ? words_left[4:0] : max_words;
    next_addr   = cur_addr + ({{(AW-5){1'b0}}, burst_words} << WB_LG2);
  end
endmodule

// File: rtl/frame_fetch_seq.sv
module frame_fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int WB_LG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic [1:0]    load_sel,
  input  logic [2:0]    burst_sel,
  input  logic          alt_buf_en,
  input  logic [AW-1:0] lut_base,
  input  logic          lut_wide,
  input  logic [AW-1:0] buf0_start,
  input  logic [AW-1:0] buf0_ceil,
  input  logic [AW-1:0] buf1_start,
  input  logic [AW-1:0] buf1_ceil,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [4:0]    rd_words,
  input  logic          rd_ack,
  output logic          frm0_done,
  output logic          frm1_done,
  output logic          lut_done
);
  seq_state_t    state_q, state_d;
  logic [1:0]    mode_q;
  logic [4:0]    bmax_q;
  logic          in_lut_q, buf_q;
  logic [AW-1:0] addr_q, ceil_q;
  logic          f0_q, f1_q, lut_q;

  logic          start_evt, burst_done, seg_done, load_seg;
  logic          nxt_lut, nxt_buf;
  logic [AW-1:0] seg_start, seg_ceil, next_addr;
  logic [4:0]    burst_words;
  logic          final_burst;

  fetch_seg_sel #(.AW(AW)) u_seg (
    .to_lut(nxt_lut), .buf_sel(nxt_buf), .lut_base(lut_base), .lut_wide(lut_wide),
    .buf0_start(buf0_start), .buf0_ceil(buf0_ceil),
    .buf1_start(buf1_start), .buf1_ceil(buf1_ceil),
    .seg_start(seg_start), .seg_ceil(seg_ceil)
  );

  fetch_burst_calc #(.AW(AW), .WB_LG2(WB_LG2)) u_burst (
    .cur_addr(addr_q), .cur_ceil(ceil_q), .max_words(bmax_q),
    .burst_words(burst_words), .final_burst(final_burst), .next_addr(next_addr)
  );

  assign start_evt  = (state_q == ST_IDLE) && fetch_en && burst_code_ok(burst_sel)
                      && (load_sel != 2'd3);
  assign burst_done = (state_q == ST_FETCH) && rd_ack;
  assign seg_done   = burst_done && final_burst;

  always_comb begin
    state_d  = state_q;
    load_seg = 1'b0;
    nxt_lut  = 1'b0;
    nxt_buf  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_evt) begin
        load_seg = 1'b1;
        nxt_lut  = (load_sel != LS_FRM_ONLY);
        state_d  = ST_FETCH;
      end
      ST_FETCH: if (burst_done) begin
        if (!fetch_en) begin
          state_d = ST_IDLE;
        end else if (seg_done) begin
          if (in_lut_q && mode_q == LS_LUT_ONLY) begin
            state_d = ST_HOLD;
          end else begin
            load_seg = 1'b1;
            nxt_buf  = in_lut_q ? 1'b0 : (alt_buf_en ? ~buf_q : 1'b0);
          end
        end
      end
      ST_HOLD: if (!fetch_en) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= LS_LUT_FRM;
      bmax_q   <= 5'd1;
      in_lut_q <= 1'b0;
      buf_q    <= 1'b0;
      addr_q   <= '0;
      ceil_q   <= '0;
      f0_q     <= 1'b0;
      f1_q     <= 1'b0;
      lut_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_evt) begin
        mode_q <= load_sel;
        bmax_q <= burst_code_words(burst_sel);
      end
      if (load_seg) begin
        addr_q   <= seg_start;
        ceil_q   <= seg_ceil;
        in_lut_q <= nxt_lut;
        buf_q    <= nxt_buf;
      end else if (burst_done) begin
        addr_q <= next_addr;
      end
      f0_q  <= seg_done && !in_lut_q && !buf_q;
      f1_q  <= seg_done && !in_lut_q && buf_q;
      lut_q <= seg_done && in_lut_q;
    end
  end

  assign rd_req    = (state_q == ST_FETCH);
  assign rd_addr   = addr_q;
  assign rd_words  = burst_words;
  assign frm0_done = f0_q;
  assign frm1_done = f1_q;
  assign lut_done  = lut_q;

  logic [AW:0] req_last_byte;
  assign req_last_byte = {1'b0, rd_addr} + ({{(AW-4){1'b0}}, rd_words} << WB_LG2) - 1'b1;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_words)));

  // R4
  no_past_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (req_last_byte <= {1'b0, ceil_q}));

  // R2
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_words != 5'd0 && rd_words <= bmax_q));

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm0_done, frm1_done, lut_done}));

  // R5
  flag_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm0_done || frm1_done || lut_done) |-> $past(rd_req && rd_ack));

  // R13
  bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !burst_code_ok(burst_sel)) |=> !rd_req);
endmodule

// File: tb/frame_fetch_seq_tb_top.sv
module frame_fetch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_en = 1'b0;
  logic [1:0]    load_sel = 2'd2;
  logic [2:0]    burst_sel = 3'd0;
  logic          alt_buf_en = 1'b0;
  logic [AW-1:0] lut_base = '0;
  logic          lut_wide = 1'b0;
  logic [AW-1:0] buf0_start = '0, buf0_ceil = '0, buf1_start = '0, buf1_ceil = '0;
  logic          rd_req, rd_ack = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [4:0]    rd_words;
  logic          frm0_done, frm1_done, lut_done;

  int n_chk = 0;
  int n_fail = 0;
  int addr_log[64];
  int len_log[64];
  int nlog = 0;
  int ev_log[32];
  int nev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_fetch_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .load_sel(load_sel),
    .burst_sel(burst_sel), .alt_buf_en(alt_buf_en), .lut_base(lut_base),
    .lut_wide(lut_wide), .buf0_start(buf0_start), .buf0_ceil(buf0_ceil),
    .buf1_start(buf1_start), .buf1_ceil(buf1_ceil), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_words(rd_words), .rd_ack(rd_ack),
    .frm0_done(frm0_done), .frm1_done(frm1_done), .lut_done(lut_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    fetch_en = 1'b0;
    rd_ack = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nlog = 0;
    nev = 0;
  endtask

  task automatic note_events();
    if (frm0_done && nev < 32) begin ev_log[nev] = 0; nev++; end
    if (frm1_done && nev < 32) begin ev_log[nev] = 1; nev++; end
    if (lut_done && nev < 32) begin ev_log[nev] = 2; nev++; end
  endtask

  // Acknowledge n bursts; optionally drop fetch_en together with the last acknowledge.
  task automatic serve(input int n, input bit stop_last);
    int got = 0;
    int guard = 0;
    while (!(got == n && rd_ack == 1'b0) && guard < 4000) begin
      @(negedge clk);
      guard++;
      note_events();
      if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (rd_req && got < n) begin
        if (nlog < 64) begin
          addr_log[nlog] = int'(rd_addr);
          len_log[nlog] = int'(rd_words);
          nlog++;
        end
        rd_ack = 1'b1;
        got++;
        if (got == n && stop_last) fetch_en = 1'b0;
      end
    end
    if (guard >= 4000) chk(1'b0, "serve timeout", got, n);
  endtask

  task automatic exp_burst(input int idx, input int a, input int l, input string req);
    chk(addr_log[idx] == a, req, addr_log[idx], a);
    chk(len_log[idx] == l, req, len_log[idx], l);
  endtask

  task automatic quiet_for(input int cyc, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (rd_req) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk({rd_req, frm0_done, frm1_done, lut_done} == 4'b0, "R1 in reset",
        int'({rd_req, frm0_done, frm1_done, lut_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rd_req, frm0_done, frm1_done, lut_done} == 4'b0, "R1 after reset",
        int'({rd_req, frm0_done, frm1_done, lut_done}), 0);
  endtask

  task automatic t_single_clip();
    do_reset();
    load_sel = 2'd2; burst_sel = 3'd2; alt_buf_en = 1'b0;
    buf0_start = 32'h100; buf0_ceil = 32'h127;
    buf1_start = 32'h500; buf1_ceil = 32'h50F;
    fetch_en = 1'b1;
    serve(4, 1'b1);
    exp_burst(0, 32'h100, 4, "R9 R2 first burst");
    exp_burst(1, 32'h110, 4, "R3 step");
    exp_burst(2, 32'h120, 2, "R4 clipped tail");
    exp_burst(3, 32'h100, 4, "R6 single buffer repeat");
    chk(nev == 1 && ev_log[0] == 0, "R5 one frm0_done", nev, 1);
    @(negedge clk);
    chk(!rd_req, "R11 stop after ack", int'(rd_req), 0);
  endtask

  task automatic t_dual();
    do_reset();
    load_sel = 2'd2; burst_sel = 3'd3; alt_buf_en = 1'b1;
    buf0_start = 32'h200; buf0_ceil = 32'h21F;
    buf1_start = 32'h400; buf1_ceil = 32'h40F;
    fetch_en = 1'b1;
    serve(3, 1'b1);
    exp_burst(0, 32'h200, 8, "R6 buffer0 first");
    exp_burst(1, 32'h400, 4, "R6 buffer1 second");
    exp_burst(2, 32'h200, 8, "R6 back to buffer0");
    chk(nev == 3, "R5 flag count", nev, 3);
    chk(ev_log[0] == 0 && ev_log[1] == 1 && ev_log[2] == 0, "R5 flag order",
        ev_log[1], 1);
  endtask

  task automatic t_lut_then_frames();
    do_reset();
    load_sel = 2'd0; burst_sel = 3'd4; alt_buf_en = 1'b0; lut_wide = 1'b0;
    lut_base = 32'h800; buf0_start = 32'h100; buf0_ceil = 32'h13F;
    fetch_en = 1'b1;
    serve(2, 1'b1);
    exp_burst(0, 32'h800, 8, "R7 small table");
    exp_burst(1, 32'h100, 16, "R7 frames follow");
    chk(nev == 2 && ev_log[0] == 2 && ev_log[1] == 0, "R7 lut_done then frm0_done",
        ev_log[0], 2);
  endtask

  task automatic t_lut_only();
    do_reset();
    load_sel = 2'd1; burst_sel = 3'd4; lut_wide = 1'b1; lut_base = 32'hC00;
    fetch_en = 1'b1;
    serve(8, 1'b0);
    for (int i = 0; i < 8; i++) exp_burst(i, 32'hC00 + 64 * i, 16, "R7 wide table");
    chk(nev == 1 && ev_log[0] == 2, "R8 single lut_done", nev, 1);
    quiet_for(6, "R8 no request while held");
    fetch_en = 1'b0;
    repeat (2) @(negedge clk);
    fetch_en = 1'b1;
    @(negedge clk);
    chk(rd_req && rd_addr == 32'hC00, "R8 restart after toggle", int'(rd_addr), 32'hC00);
  endtask

  task automatic t_invalid();
    do_reset();
    load_sel = 2'd2; burst_sel = 3'd5;
    buf0_start = 32'h100; buf0_ceil = 32'h10F;
    fetch_en = 1'b1;
    quiet_for(8, "R13 burst code 5");
    burst_sel = 3'd7;
    quiet_for(6, "R13 burst code 7");
    burst_sel = 3'd2; load_sel = 2'd3;
    quiet_for(8, "R13 load code 3");
    fetch_en = 1'b0;
  endtask

  task automatic t_rewrite();
    do_reset();
    load_sel = 2'd2; burst_sel = 3'd2; alt_buf_en = 1'b0;
    buf0_start = 32'h100; buf0_ceil = 32'h11F;
    fetch_en = 1'b1;
    serve(1, 1'b0);
    buf0_start = 32'h300; buf0_ceil = 32'h30F;
    serve(2, 1'b1);
    exp_burst(1, 32'h110, 4, "R10 old descriptor kept");
    exp_burst(2, 32'h300, 4, "R10 new descriptor next pass");
  endtask

  task automatic t_small_bursts();
    do_reset();
    load_sel = 2'd2; burst_sel = 3'd0;
    buf0_start = 32'h100; buf0_ceil = 32'h107;
    fetch_en = 1'b1;
    serve(2, 1'b1);
    exp_burst(0, 32'h100, 1, "R2 code0");
    exp_burst(1, 32'h104, 1, "R3 code0 step");
    do_reset();
    burst_sel = 3'd1; buf0_ceil = 32'h10B;
    fetch_en = 1'b1;
    serve(2, 1'b1);
    exp_burst(0, 32'h100, 2, "R2 code1");
    exp_burst(1, 32'h108, 1, "R4 code1 tail");
  endtask

  task automatic t_pending_drop();
    bit held = 1'b1;
    do_reset();
    load_sel = 2'd2; burst_sel = 3'd2;
    buf0_start = 32'h100; buf0_ceil = 32'h13F;
    fetch_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    fetch_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!(rd_req && rd_addr == 32'h100 && rd_words == 5'd4)) held = 1'b0;
    end
    chk(held, "R12 R11 request held until ack", int'(held), 1);
    serve(1, 1'b0);
    quiet_for(5, "R11 no request after ack");
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single_clip();
    t_dual();
    t_lut_then_frames();
    t_lut_only();
    t_invalid();
    t_rewrite();
    t_small_bursts();
    t_pending_drop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule